// File: doc/BRIEF.md
# Table-Driven Three-Button Combination Lock

The block is a lock controller whose transitions are not hard-wired: a small table held in registers decides, for every current state and every combination of the three buttons, which state comes next and whether the lock is open. The state sits in a register whose width is a parameter (three bits by default). The lookup address joins that state with the three button bits. Each button arrives as a pulse that is one clock wide and already synchronized. The buttons are a return-to-start button, a "0" button and a "1" button.

Software or a boot sequencer fills the table through a simple write port. While a write is in progress the lock is held at state zero. A synchronous power-on reset, which is separate from the return-to-start button, clears the state and loads a default table. In the default table every state maps to itself for every button combination, so a freshly reset lock does nothing until it is programmed. The table alone decides what happens when several buttons are pressed together, and whether the open state is sticky.

Top module: `seq_lock_table`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 0 and `unlock` becomes 0 after that edge.
- R2: After `rst`, every table entry holds its own state with unlock 0, so no button pattern moves the lock from state 0 until the table is written.
- R3: On an edge where `tbl_we` is high (and `rst` is low), entry `tbl_addr` takes `tbl_wdata`, and the state and `unlock` are forced to 0 whatever the buttons are.
- R4: On an edge with `rst` and `tbl_we` low, the state takes bits [STATE_W-1:0] of the entry at the current lookup address. The change shows one cycle later.
- R5: `unlock` is registered together with the state. It takes bit STATE_W of the same entry, so it follows the registered state and never the raw buttons.
- R6: The lookup address is {state, btn_reset, btn_one, btn_zero}. The state is in the upper bits, the return-to-start button is bit 2, "1" is bit 1 and "0" is bit 0.
- R7: A cycle with no button pressed uses the entries whose low three bits are 000. With hold entries loaded there, idle cycles keep the state.
- R8: When "0" and "1" are pressed together, the lock does what the table says. Entries whose low bits are 011 and that map to the current state leave the state unchanged.
- R9: If the table maps the open state to itself for every button pattern, `unlock` stays at 1 through any later presses until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous power-on reset; clears state and loads the default table |
| btn_reset | input | 1 | Return-to-start button pulse |
| btn_zero | input | 1 | "0" button pulse |
| btn_one | input | 1 | "1" button pulse |
| tbl_we | input | 1 | Table write enable; holds the lock at state 0 |
| tbl_addr | input | STATE_W+3 | Table write address |
| tbl_wdata | input | STATE_W+1 | Table write word: {unlock, next state} |
| state_o | output | STATE_W | Current registered state |
| unlock | output | 1 | Open indication, registered with the state |

## Verification
The bench uses the default STATE_W of 3, which gives a 64-entry table. The bench fills all 64 entries for the combination 0,1,1, with state 7 as the sticky open state. It also exercises the default hold table before any load and again after a second reset. This setting makes it possible to walk a correct sequence and a wrong one, to press "0" and "1" together mid-sequence, to press the return-to-start button, and to rewrite an entry while a button is held. Every bit of the lookup address and of the table word is therefore driven at least once.

// File: rtl/seq_lock_table.sv
module seq_lock_table #(
  parameter int STATE_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 btn_reset,
  input  logic                 btn_zero,
  input  logic                 btn_one,
  input  logic                 tbl_we,
  input  logic [STATE_W+2:0]   tbl_addr,
  input  logic [STATE_W:0]     tbl_wdata,
  output logic [STATE_W-1:0]   state_o,
  output logic                 unlock
);
  localparam int BTN_W  = 3;
  localparam int ADDR_W = STATE_W + BTN_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = STATE_W + 1;

  logic [WORD_W-1:0]  tbl [DEPTH];
  logic [STATE_W-1:0] state_q;
  logic               unlock_q;

  wire [ADDR_W-1:0] rd_addr = {state_q, btn_reset, btn_one, btn_zero};
  wire [WORD_W-1:0] rd_word = tbl[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        tbl[i] <= {1'b0, STATE_W'(i >> BTN_W)};
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tbl_we) begin
      state_q  <= '0;
      unlock_q <= 1'b0;
    end else begin
      state_q  <= rd_word[STATE_W-1:0];
      unlock_q <= rd_word[STATE_W];
    end
  end

  assign state_o = state_q;
  assign unlock  = unlock_q;
endmodule

// File: rtl/seq_lock_table_chk.sv
module seq_lock_table_chk #(
  parameter int STATE_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               btn_reset,
  input logic               btn_zero,
  input logic               btn_one,
  input logic               tbl_we,
  input logic [STATE_W+2:0] tbl_addr,
  input logic [STATE_W:0]   tbl_wdata,
  input logic [STATE_W-1:0] state_o,
  input logic               unlock
);
  localparam int ADDR_W = STATE_W + 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [STATE_W:0] shadow [DEPTH];
  logic [STATE_W:0] exp_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        shadow[i] <= {1'b0, STATE_W'(i >> 3)};
    end else if (tbl_we) begin
      shadow[tbl_addr] <= tbl_wdata;
    end
  end

  assign exp_word = shadow[{state_o, btn_reset, btn_one, btn_zero}];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state_o == '0 && !unlock)); // R1
  AST_WRITE_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> (state_o == '0 && !unlock)); // R3
  AST_NEXT_FROM_TABLE: assert property (@(posedge clk) disable iff (rst)
    !tbl_we |=> state_o == $past(exp_word[STATE_W-1:0])); // R4
  AST_UNLOCK_FROM_TABLE: assert property (@(posedge clk) disable iff (rst)
    !tbl_we |=> unlock == $past(exp_word[STATE_W])); // R5
endmodule

bind seq_lock_table seq_lock_table_chk #(.STATE_W(STATE_W)) u_chk (
  .clk(clk), .rst(rst), .btn_reset(btn_reset), .btn_zero(btn_zero),
  .btn_one(btn_one), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
  .tbl_wdata(tbl_wdata), .state_o(state_o), .unlock(unlock)
);

// File: tb/seq_lock_table_tb.sv
module seq_lock_table_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_reset = 1'b0, btn_zero = 1'b0, btn_one = 1'b0;
  logic       tbl_we = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [3:0] tbl_wdata = '0;
  logic [2:0] state_o;
  logic       unlock;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  seq_lock_table u_dut (
    .clk(clk), .rst(rst), .btn_reset(btn_reset), .btn_zero(btn_zero),
    .btn_one(btn_one), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .state_o(state_o), .unlock(unlock)
  );

  task automatic chk(input string req, input logic [2:0] es, input logic eu);
    n_run++;
    if (state_o !== es || unlock !== eu) begin
      n_fail++;
      $display("FAIL %s: state=%0d unlock=%0b expected state=%0d unlock=%0b",
               req, state_o, unlock, es, eu);
    end
  endtask

  // combination 0,1,1 ; state 7 is the sticky open state
  function automatic logic [3:0] entry(input logic [2:0] s, input logic [2:0] c);
    logic [2:0] n;
    if (s == 3'd7)           n = 3'd7;
    else if (c == 3'b100)    n = 3'd0;
    else if (c == 3'b001)    n = 3'd1;
    else if (c == 3'b010)    n = (s == 3'd1) ? 3'd2 : (s == 3'd2) ? 3'd7 : 3'd0;
    else                     n = s;
    return {n == 3'd7, n};
  endfunction

  task automatic press(input logic r, input logic o, input logic z);
    @(negedge clk);
    btn_reset = r; btn_one = o; btn_zero = z;
    @(negedge clk);
    btn_reset = 0; btn_one = 0; btn_zero = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic load_table();
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = 6'(a); tbl_wdata = entry(3'(a >> 3), 3'(a));
    end
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic t_reset_and_defaults();
    do_reset();
    chk("R1 reset", 3'd0, 1'b0);
    press(0, 0, 1); chk("R2 default zero", 3'd0, 1'b0);
    press(0, 1, 0); chk("R2 default one", 3'd0, 1'b0);
    press(0, 1, 1); chk("R2 default both", 3'd0, 1'b0);
  endtask

  task automatic t_correct_seq();
    load_table();
    chk("R3 after load", 3'd0, 1'b0);
    press(0, 0, 1); chk("R4 R6 first zero", 3'd1, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R7 idle hold", 3'd1, 1'b0);
    press(0, 1, 0); chk("R4 second", 3'd2, 1'b0);
    press(0, 1, 0); chk("R5 open", 3'd7, 1'b1);
    press(1, 0, 0); chk("R9 sticky reset btn", 3'd7, 1'b1);
    press(0, 0, 1); chk("R9 sticky zero", 3'd7, 1'b1);
  endtask

  task automatic t_wrong_and_simul();
    do_reset();
    load_table();
    press(0, 0, 1); press(0, 0, 1); press(0, 1, 0);
    chk("R4 wrong seq", 3'd2, 1'b0);
    press(0, 1, 1); chk("R8 simultaneous hold", 3'd2, 1'b0);
    press(1, 0, 0); chk("R6 reset button bit2", 3'd0, 1'b0);
    press(0, 0, 1); press(0, 1, 0);
    chk("R4 back to 2", 3'd2, 1'b0);
    @(negedge clk);
    btn_one = 1; tbl_we = 1; tbl_addr = 6'd0; tbl_wdata = entry(3'd0, 3'd0);
    @(negedge clk);
    btn_one = 0; tbl_we = 0;
    chk("R3 write forces zero", 3'd0, 1'b0);
  endtask

  task automatic t_reset_restores();
    do_reset();
    chk("R1 second reset", 3'd0, 1'b0);
    press(0, 0, 1); chk("R2 defaults restored", 3'd0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_and_defaults();
    t_correct_seq();
    t_wrong_and_simul();
    t_reset_restores();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule